// File: doc/BRIEF.md
# Serial Byte Receiver with Overrun Lockout

This block receives asynchronous serial characters with one start bit, eight data bits and one stop bit. The line is resynchronised and then sampled at sixteen times the bit rate. A divisor input sets the sample rate in clock cycles. Each received byte goes into a two-entry queue, together with a flag that records whether its stop bit was valid. A host reads the oldest byte with a one-cycle read strobe. The host sees whether data is waiting, whether the byte at the head had a bad stop bit, and whether an overrun has happened.

An overrun happens when a byte finishes while both queue entries are already occupied. That byte is thrown away, and the receiver locks: it accepts no further frames until the host takes the receive enable low and then high again. The two bytes stored before the overrun stay readable in arrival order throughout, and dropping the enable does not clear them. At 9600 baud a character takes about 1 ms, so a host that reads each byte within that time never loses data.

Top module: `serial_rx_lockout`

## Requirements
- R1: A frame is a low start bit, eight data bits least significant bit first, then a stop bit. Each bit lasts 16*max(baud_div,1) clock cycles. A received byte appears on rd_data with data_avail high.
- R2: Stored bytes sit in a two-entry queue. A byte that completes while two entries are occupied is discarded, and overrun_flag goes high.
- R3: While overrun_flag is high and rx_enable stays high, every incoming frame is ignored, including frames that arrive after the queue has been emptied.
- R4: After an overrun, the two stored bytes are read out in the order they arrived.
- R5: Taking rx_enable low clears overrun_flag in the next cycle. Once rx_enable is high again, reception resumes. Bytes already in the queue survive the toggle.
- R6: A read strobe while data_avail is high removes the head byte. A read strobe while data_avail is low changes no output. After reset, data_avail and overrun_flag are low.
- R7: While rx_enable is low, frames on the line are not received.
- R8: A frame whose stop bit samples low is still stored. frame_err is high while that byte is at the head of the queue, and low for bytes with a valid stop bit.
- R9: A low pulse shorter than half a bit period is rejected as a false start and stores nothing.
- R10: Frames sent back to back, with each start bit directly after the previous stop bit, are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receive enable; a low-then-high toggle clears the overrun lockout |
| baud_div | input | 16 | Clock cycles per 1/16 bit (0 is treated as 1) |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| rd_strobe | input | 1 | One-cycle pop of the head byte |
| rd_data | output | 8 | Head byte; valid only while data_avail is high |
| data_avail | output | 1 | Queue holds at least one byte |
| overrun_flag | output | 1 | Sticky overrun; the receiver is locked while it is high |
| frame_err | output | 1 | The head byte had a low stop bit |

## Verification
The bench drives several patterns:
- **Single, paired and back-to-back bytes at two divisor settings.** These separate correct bit order and timing from an off-by-one in the sampler.
- **A short glitch and a frame with a low stop bit.** These tell a false start apart from a real character, and a framing fault apart from a dropped byte.
- **Three and then four unread frames, followed by draining and one more frame.** This distinguishes overwriting a stored byte from dropping the new one, and a lock that releases on drain from one that holds until the enable toggles.
- **A frame sent while the enable is low, and an enable toggle with a byte stored.** These check that the enable blocks reception but keeps the queue.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rxl_sync.sv
module rxl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/rxl_tick.sv
module rxl_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (div == '0) ? '0 : div - 1'b1;
        st_d  = st_q;
        if (!run) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b0;
        end else if (st_q.cnt >= limit) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    // R1: a tick is never followed by another within a divisor of two or more
    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && $stable(div) && div > 1) |=> !tick);
endmodule

// File: rtl/rxl_frame.sv
module rxl_frame
    import serial_rx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hold,
    input  logic                 tick,
    input  logic                 line,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 ferr
);
    localparam int CW   = $clog2(OVS);
    localparam int BW   = $clog2(DATA_BITS);
    localparam logic [CW-1:0] HALF_M1 = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);
    localparam logic [BW-1:0] LAST_B  = BW'(DATA_BITS - 1);

    typedef struct packed {
        rx_state_e            state;
        logic [CW-1:0]        tcnt;
        logic [BW-1:0]        bidx;
        logic [DATA_BITS-1:0] shreg;
        logic                 done;
        logic                 ferr;
        logic [DATA_BITS-1:0] data;
    } frame_st_t;

    localparam frame_st_t RESET_ST = '{state: ST_IDLE, default: '0};

    frame_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (hold) begin
            st_d = RESET_ST;
            st_d.data = st_q.data;
            st_d.ferr = st_q.ferr;
        end else if (tick) begin
            unique case (st_q.state)
                ST_IDLE: begin
                    if (!line) begin
                        st_d.state = ST_START;
                        st_d.tcnt  = '0;
                    end
                end
                ST_START: begin
                    if (st_q.tcnt == HALF_M1) begin
                        st_d.tcnt = '0;
                        st_d.bidx = '0;
                        st_d.state = line ? ST_IDLE : ST_DATA;
                    end else begin
                        st_d.tcnt = st_q.tcnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (st_q.tcnt == FULL_M1) begin
                        st_d.tcnt  = '0;
                        st_d.shreg = {line, st_q.shreg[DATA_BITS-1:1]};
                        if (st_q.bidx == LAST_B) st_d.state = ST_STOP;
                        else                     st_d.bidx  = st_q.bidx + 1'b1;
                    end else begin
                        st_d.tcnt = st_q.tcnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (st_q.tcnt == FULL_M1) begin
                        st_d.tcnt  = '0;
                        st_d.done  = 1'b1;
                        st_d.data  = st_q.shreg;
                        st_d.ferr  = ~line;
                        st_d.state = ST_IDLE;
                    end else begin
                        st_d.tcnt = st_q.tcnt + 1'b1;
                    end
                end
                default: st_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign data = st_q.data;
    assign ferr = st_q.ferr;

    // R7: holding forces the sampler idle with no completion
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (st_q.state == ST_IDLE && !done));
    // R1: completion is a single-cycle pulse
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/rxl_fifo.sv
module rxl_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop  && (st_q.cnt != '0);
        do_push = push && (st_q.cnt != CAP);
        if (do_push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CAP);

    // R6: a pop on an empty queue leaves its occupancy alone
    p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
    // R2: a push into a full queue overwrites no stored byte
    p_full_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> ($stable(st_q.mem) && full));
endmodule

// File: rtl/serial_rx_lockout.sv
module serial_rx_lockout #(
    parameter int DIV_W     = 16,
    parameter int OVS       = 16,
    parameter int DATA_BITS = 8,
    parameter int DEPTH     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_enable,
    input  logic [DIV_W-1:0]     baud_div,
    input  logic                 serial_in,
    input  logic                 rd_strobe,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 data_avail,
    output logic                 overrun_flag,
    output logic                 frame_err
);
    localparam int EW = DATA_BITS + 1;

    typedef struct packed {
        logic ovr;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic                 line_s, tick, hold;
    logic                 fr_done, fr_ferr;
    logic [DATA_BITS-1:0] fr_data;
    logic [EW-1:0]        head;
    logic                 q_empty, q_full, q_push;

    rxl_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(serial_in), .sync_out(line_s)
    );

    rxl_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(!hold), .div(baud_div), .tick(tick)
    );

    rxl_frame #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_frame (
        .clk(clk), .rst_n(rst_n), .hold(hold), .tick(tick), .line(line_s),
        .done(fr_done), .data(fr_data), .ferr(fr_ferr)
    );

    rxl_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(q_push), .wdata({fr_ferr, fr_data}),
        .pop(rd_strobe), .rdata(head), .empty(q_empty), .full(q_full)
    );

    always_comb begin
        hold   = !rx_enable || st_q.ovr;
        q_push = fr_done && rx_enable && !st_q.ovr;
        st_d   = st_q;
        if (!rx_enable)            st_d.ovr = 1'b0;
        else if (q_push && q_full) st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data      = head[DATA_BITS-1:0];
    assign data_avail   = !q_empty;
    assign frame_err    = !q_empty && head[DATA_BITS];
    assign overrun_flag = st_q.ovr;

    // R2: a completion into a full queue raises the overrun flag
    p_ovr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && q_full && rx_enable && !overrun_flag) |=> overrun_flag);
    // R3: the lockout persists while enabled
    p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_flag && rx_enable) |=> overrun_flag);
    // R3: no completion is produced while locked
    p_no_rx_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_flag && $past(overrun_flag)) |-> !fr_done);
    // R5: disabling clears the lockout
    p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !overrun_flag);
    // R5: disabling does not disturb the stored bytes
    p_keep_on_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && !rd_strobe) |=> $stable(data_avail));
endmodule

// File: tb/serial_rx_lockout_test.sv
module serial_rx_lockout_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_enable;
    logic [15:0] baud_div;
    logic        serial_in;
    logic        rd_strobe;
    logic [7:0]  rd_data;
    logic        data_avail, overrun_flag, frame_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic       cmp_en = 1'b0;
    logic       frame_evt = 1'b0;
    logic [8:0] evt_word = '0;
    logic [8:0] mq[$];
    logic       m_ovr = 1'b0;

    always #5 clk = ~clk;

    serial_rx_lockout uut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .baud_div(baud_div),
        .serial_in(serial_in), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .data_avail(data_avail), .overrun_flag(overrun_flag), .frame_err(frame_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference model: queue of {ferr,data}, sticky overrun
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_ovr = 1'b0;
        end else begin
            if (rd_strobe && mq.size() > 0) void'(mq.pop_front());
            if (frame_evt && rx_enable && !m_ovr) begin
                if (mq.size() >= 2) m_ovr = 1'b1;
                else                mq.push_back(evt_word);
            end
            if (!rx_enable) m_ovr = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk("R6 data_avail vs model", 32'(data_avail), 32'(mq.size() > 0));
            chk("R3 overrun_flag vs model", 32'(overrun_flag), 32'(m_ovr));
            if (mq.size() > 0) begin
                chk("R4 rd_data vs model", 32'(rd_data), 32'(mq[0][7:0]));
                chk("R8 frame_err vs model", 32'(frame_err), 32'(mq[0][8]));
            end else begin
                chk("R8 frame_err empty", 32'(frame_err), 32'd0);
            end
        end
    end

    task automatic send_frame(input logic [7:0] b, input logic stopv, input int gap_bits);
        int bitc;
        bitc = 16 * ((baud_div == 0) ? 1 : int'(baud_div));
        cmp_en = 1'b0;
        serial_in = 1'b0;
        repeat (bitc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            serial_in = b[i];
            repeat (bitc) @(negedge clk);
        end
        serial_in = stopv;
        repeat (bitc) @(negedge clk);
        serial_in = 1'b1;
        evt_word  = {~stopv, b};
        frame_evt = 1'b1;
        @(negedge clk);
        frame_evt = 1'b0;
        cmp_en    = 1'b1;
        repeat (gap_bits * bitc) @(negedge clk);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; rx_enable = 1'b0; baud_div = 16'd4;
        serial_in = 1'b1; rd_strobe = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset data_avail", 32'(data_avail), 0);
        chk("R6 reset overrun", 32'(overrun_flag), 0);
        rx_enable = 1'b1;
        cmp_en = 1'b1;
        repeat (40) @(negedge clk);

        // R1 single byte
        send_frame(8'hA5, 1'b1, 2);
        chk("R1 byte A5 avail", 32'(data_avail), 1);
        chk("R1 byte A5 data", 32'(rd_data), 32'hA5);
        chk("R8 good stop no ferr", 32'(frame_err), 0);
        do_read();
        chk("R6 pop empties", 32'(data_avail), 0);

        // R10 back-to-back
        send_frame(8'h3C, 1'b1, 0);
        send_frame(8'h81, 1'b1, 2);
        chk("R10 first b2b", 32'(rd_data), 32'h3C);
        do_read();
        chk("R10 second b2b", 32'(rd_data), 32'h81);
        do_read();

        // R9 false start
        cmp_en = 1'b0;
        serial_in = 1'b0;
        repeat (12) @(negedge clk);
        serial_in = 1'b1;
        repeat (200) @(negedge clk);
        cmp_en = 1'b1;
        chk("R9 glitch stores nothing", 32'(data_avail), 0);

        // R8 framing error
        send_frame(8'h5A, 1'b0, 3);
        chk("R8 bad stop stored", 32'(rd_data), 32'h5A);
        chk("R8 bad stop flagged", 32'(frame_err), 1);
        do_read();

        // R6 empty read
        do_read();
        chk("R6 empty read avail", 32'(data_avail), 0);
        chk("R6 empty read overrun", 32'(overrun_flag), 0);

        // R2 overrun
        send_frame(8'h11, 1'b1, 1);
        send_frame(8'h22, 1'b1, 1);
        chk("R2 no overrun at two", 32'(overrun_flag), 0);
        send_frame(8'h33, 1'b1, 1);
        chk("R2 overrun set", 32'(overrun_flag), 1);
        chk("R2 head unchanged", 32'(rd_data), 32'h11);
        send_frame(8'h44, 1'b1, 1);
        chk("R3 still locked", 32'(overrun_flag), 1);
        chk("R4 first after ovr", 32'(rd_data), 32'h11);
        do_read();
        chk("R4 second after ovr", 32'(rd_data), 32'h22);
        do_read();
        chk("R4 drained", 32'(data_avail), 0);
        send_frame(8'h55, 1'b1, 1);
        chk("R3 ignored after drain", 32'(data_avail), 0);
        chk("R3 overrun held", 32'(overrun_flag), 1);

        // R5 / R7 enable
        rx_enable = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 disable clears overrun", 32'(overrun_flag), 0);
        send_frame(8'h66, 1'b1, 1);
        chk("R7 disabled ignores frame", 32'(data_avail), 0);
        rx_enable = 1'b1;
        repeat (10) @(negedge clk);
        send_frame(8'h77, 1'b1, 1);
        chk("R5 resumes after toggle", 32'(rd_data), 32'h77);
        chk("R5 resumed avail", 32'(data_avail), 1);
        rx_enable = 1'b0;
        repeat (5) @(negedge clk);
        rx_enable = 1'b1;
        repeat (5) @(negedge clk);
        chk("R5 queue kept over toggle", 32'(rd_data), 32'h77);
        do_read();

        // R1 other divisor
        baud_div = 16'd2;
        repeat (40) @(negedge clk);
        send_frame(8'h96, 1'b1, 2);
        chk("R1 divisor 2 data", 32'(rd_data), 32'h96);
        do_read();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule